// File: doc/BRIEF.md
# Triggered DAC Sample Transfer Controller

This block sits between a software-written 12-bit holding register and the output data register that feeds a digital-to-analog converter. In free-running mode every write to the holding register is copied to the output on the next clock. With triggering enabled, the copy is instead launched by one of eight selectable events. Seven are hardware inputs (six timer event lines and one external line), all detected on their rising edge. The eighth is a software trigger bit.

A hardware trigger leads to a three-cycle transfer. A software trigger leads to a one-cycle transfer. When DMA mode is on, each accepted hardware trigger asks the DMA engine for the next sample. If a further trigger is accepted before the holding register has been refilled, the block raises a sticky underrun flag, which can also drive an interrupt. Software configures the block through a small write-only register port.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset, `dac_data` is 0 and `dma_req`, `underrun`, `underrun_irq` and `sw_trig_pending` are all 0.
- R2: With the trigger enable (control bit 0) at 0, a write to address 1 stores `reg_wdata[11:0]` in the holding register, and `dac_data` takes that value exactly one clock after the holding register is loaded.
- R3: With the trigger enable at 1, a write to the holding register leaves `dac_data` unchanged until a trigger is accepted.
- R4: With the trigger enable at 1 and a select code of 0 to 6 (control bits 3:1), a rising edge on `hw_trig_in[code]` is accepted at the first clock that samples the input high. `dac_data` takes the holding value three clocks after that accepting clock.
- R5: Hardware inputs other than the selected one are ignored, and every trigger source is ignored while the trigger enable is 0.
- R6: A hardware trigger that arrives at any of the three clocks following an accepted trigger is ignored.
- R7: Select code 7 picks the software trigger. Writing 1 to bit 0 of address 3 sets `sw_trig_pending`, `dac_data` takes the holding value at the next clock, and `sw_trig_pending` clears one clock after that transfer. The write is ignored unless the trigger enable is 1 and the select code is 7.
- R8: With DMA enable (control bit 4) at 1, each accepted hardware trigger makes `dma_req` high for exactly one cycle, starting at the accepting clock. With DMA enable at 0, `dma_req` stays 0.
- R9: In DMA mode, a request stays outstanding until the holding register is written. A hardware trigger accepted while a request is outstanding sets the sticky `underrun` flag. A holding write at the same clock as the trigger counts as servicing the request first.
- R10: `underrun_irq` is high only while `underrun` is 1 and the interrupt enable (control bit 5) is 1. Writing 1 to bit 0 of address 2 clears `underrun`. A new underrun at the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 holding data, 2 flag clear, 3 software trigger |
| reg_wdata | input | 12 | Register write data |
| hw_trig_in | input | 7 | Hardware trigger lines: bits 5:0 timer events, bit 6 external line |
| dac_data | output | 12 | Output data register driving the converter |
| dma_req | output | 1 | One-cycle DMA request |
| underrun | output | 1 | Sticky DMA underrun flag |
| underrun_irq | output | 1 | Underrun interrupt |
| sw_trig_pending | output | 1 | Software trigger bit |

## Verification
The transfer path is driven four ways: back-to-back direct writes, which show the one-cycle copy; a pulse on an unselected line followed by the selected one, which separates a correct select decode from a wrong one; a second pulse inside the busy window followed by a fresh holding value, which exposes any re-triggering as an unexpected output change; and a software trigger, which is told apart from a hardware trigger by its latency. Every output change is matched against a queued value and arrival cycle, so a wrong latency fails as surely as a wrong value. The DMA sequence alternates serviced and unserviced triggers, so that the underrun flag, its interrupt gating and its clear are each tested against both outcomes.

// File: rtl/dac_xfer_pkg.sv
// Package: shared widths, register addresses and control layout for the
// triggered DAC transfer controller. Assumes a 3-bit trigger select code.
package dac_xfer_pkg;
    localparam int SAMPLE_W = 12;
    localparam int SEL_W    = 3;
    localparam int N_SRC    = 2 ** SEL_W;
    localparam int N_HW     = N_SRC - 1;
    localparam int HW_LAT   = 3;
    localparam int ADDR_W   = 2;

    localparam logic [SEL_W-1:0] SEL_SOFT = SEL_W'(N_SRC - 1);

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_HOLD  = 2'd1,
        A_CLEAR = 2'd2,
        A_SWTRG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             irq_en;
        logic             dma_on;
        logic [SEL_W-1:0] src_sel;
        logic             trig_on;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dac_trig_sel.sv
// Trigger source selector: detects rising edges on every hardware trigger
// line and passes on the one picked by the select code. Assumes the inputs
// are already synchronous to clk. The top code (software) never fires here.
module dac_trig_sel #(
    parameter int SEL_W = 3,
    localparam int N_SRC = 2 ** SEL_W,
    localparam int N_HW  = N_SRC - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_HW-1:0]  hw_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             enable,
    input  logic             busy,
    output logic             fire
);
    logic [N_HW-1:0]  prev_q;
    logic [N_SRC-1:0] rise_v;

    // Remember last sampled level of every line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= hw_in;
    end

    // One rising-edge detector per line; the software slot reads as zero.
    for (genvar g = 0; g < N_SRC; g++) begin : g_rise
        if (g < N_HW) begin : g_line
            assign rise_v[g] = hw_in[g] & ~prev_q[g];
        end else begin : g_soft
            assign rise_v[g] = 1'b0;
        end
    end

    // Accept the selected edge only when enabled and no transfer is running.
    always_comb fire = enable & ~busy & rise_v[sel];
endmodule

// File: rtl/dac_xfer_seq.sv
// Transfer sequencer: copies the holding value into the output register.
// A hardware trigger walks a LAT-stage shift chain and copies on its last
// stage; direct and software requests copy at the next edge. Assumes LAT >= 2.
module dac_xfer_seq #(
    parameter int DW  = 12,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hold,
    input  logic          direct_go,
    input  logic          sw_go,
    input  logic          hw_fire,
    output logic [DW-1:0] dout,
    output logic          busy
);
    logic [LAT-1:0] stage_q;

    // Track a hardware-launched transfer through its latency window.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[LAT-2:0], hw_fire};
    end

    // Load the output register when any transfer reaches completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  dout <= '0;
        else if (stage_q[LAT-1] || sw_go || direct_go) dout <= hold;
    end

    always_comb busy = |stage_q;
endmodule

// File: rtl/dac_dma_track.sv
// DMA request and underrun tracker: pulses a request per accepted hardware
// trigger, keeps it outstanding until the holding register is written, and
// sets a sticky underrun on a trigger that finds a request still open.
module dac_dma_track (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_on,
    input  logic hw_fire,
    input  logic hold_wr,
    input  logic flag_clr,
    output logic dma_req,
    output logic underrun
);
    logic open_q;
    logic miss;

    // A trigger misses when a request is open and not serviced this clock.
    always_comb miss = dma_on & hw_fire & open_q & ~hold_wr;

    // Outstanding request: set by a trigger, cleared by a holding write.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_on) open_q <= 1'b0;
        else if (hw_fire)      open_q <= 1'b1;
        else if (hold_wr)      open_q <= 1'b0;
    end

    // One-cycle request pulse per accepted trigger in DMA mode.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= dma_on & hw_fire;
    end

    // Sticky underrun flag; a new miss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        underrun <= 1'b0;
        else if (miss)     underrun <= 1'b1;
        else if (flag_clr) underrun <= 1'b0;
    end
endmodule

// File: rtl/dac_xfer_ctrl.sv
// Top: triggered DAC sample transfer controller. Holds the control and
// holding registers, the self-clearing software trigger, and ties together
// the trigger selector, transfer sequencer and DMA tracker. Assumes one
// register write per clock and synchronous trigger inputs.
module dac_xfer_ctrl
    import dac_xfer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    input  logic [N_HW-1:0]     hw_trig_in,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dma_req,
    output logic                underrun,
    output logic                underrun_irq,
    output logic                sw_trig_pending
);
    ctrl_t               ctrl_q;
    logic [SAMPLE_W-1:0] hold_q;
    logic                direct_q;
    logic                sw_done_q;
    logic                hold_wr;
    logic                ctrl_wr;
    logic                clr_wr;
    logic                sw_wr;
    logic                sw_go;
    logic                hw_fire;
    logic                xfer_busy;

    // Decode the register write strobes.
    always_comb begin
        hold_wr = reg_wr && (reg_addr == A_HOLD);
        ctrl_wr = reg_wr && (reg_addr == A_CTRL);
        clr_wr  = reg_wr && (reg_addr == A_CLEAR) && reg_wdata[0];
        sw_wr   = reg_wr && (reg_addr == A_SWTRG) && reg_wdata[0]
                  && ctrl_q.trig_on && (ctrl_q.src_sel == SEL_SOFT);
        sw_go   = sw_trig_pending && !sw_done_q;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Holding register and the untriggered copy request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            direct_q <= 1'b0;
        end else begin
            if (hold_wr) hold_q <= reg_wdata;
            direct_q <= hold_wr && !ctrl_q.trig_on;
        end
    end

    // Software trigger: set by write, copy next clock, clear one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_trig_pending <= 1'b0;
            sw_done_q       <= 1'b0;
        end else if (sw_done_q) begin
            sw_trig_pending <= 1'b0;
            sw_done_q       <= 1'b0;
        end else if (sw_go) begin
            sw_done_q       <= 1'b1;
        end else if (sw_wr) begin
            sw_trig_pending <= 1'b1;
        end
    end

    dac_trig_sel #(.SEL_W(SEL_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_in  (hw_trig_in),
        .sel    (ctrl_q.src_sel),
        .enable (ctrl_q.trig_on),
        .busy   (xfer_busy),
        .fire   (hw_fire)
    );

    dac_xfer_seq #(.DW(SAMPLE_W), .LAT(HW_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_q),
        .direct_go (direct_q),
        .sw_go     (sw_go),
        .hw_fire   (hw_fire),
        .dout      (dac_data),
        .busy      (xfer_busy)
    );

    dac_dma_track u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_on   (ctrl_q.dma_on),
        .hw_fire  (hw_fire),
        .hold_wr  (hold_wr),
        .flag_clr (clr_wr),
        .dma_req  (dma_req),
        .underrun (underrun)
    );

    // Interrupt gated by its enable.
    always_comb underrun_irq = underrun && ctrl_q.irq_en;
endmodule

// File: rtl/dac_xfer_ctrl_chk.sv
// Checker: temporal properties of the transfer controller, bound to the top.
module dac_xfer_ctrl_chk
    import dac_xfer_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [SAMPLE_W-1:0] reg_wdata,
    input logic [SAMPLE_W-1:0] dac_data,
    input logic                dma_req,
    input logic                underrun,
    input logic                underrun_irq,
    input logic                sw_trig_pending,
    input ctrl_t               ctrl_q
);
    logic hold_direct;
    logic clr_one;
    always_comb hold_direct = reg_wr && reg_addr == A_HOLD && !ctrl_q.trig_on;
    always_comb clr_one     = reg_wr && reg_addr == A_CLEAR && reg_wdata[0];

    a_r2_direct_copy: assert property (@(posedge clk) disable iff (!rst_n)
        hold_direct |=> ##1 (dac_data == $past(reg_wdata, 2)));

    a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    a_r8_req_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(ctrl_q.dma_on));

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr_one) |=> underrun);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_irq |-> (underrun && ctrl_q.irq_en));

    a_r7_sw_short: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_trig_pending) |=> ##1 !sw_trig_pending);
endmodule

bind dac_xfer_ctrl dac_xfer_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .dac_data        (dac_data),
    .dma_req         (dma_req),
    .underrun        (underrun),
    .underrun_irq    (underrun_irq),
    .sw_trig_pending (sw_trig_pending),
    .ctrl_q          (ctrl_q)
);

// File: tb/test_dac_xfer_ctrl.sv
// Scoreboard bench: drivers queue expected output values with their cycle,
// a monitor pops one per output change and compares value and arrival.
module test_dac_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [6:0]  hw_trig_in = '0;
    logic [11:0] dac_data;
    logic        dma_req, underrun, underrun_irq, sw_trig_pending;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [11:0] exp_hold = '0;
    logic [11:0] exp_dac = '0;
    logic [11:0] q_val[$];
    int          q_cyc[$];
    logic [11:0] last_dac = '0;
    logic        mon_on = 1'b0;

    dac_xfer_ctrl i_dac_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hw_trig_in(hw_trig_in), .dac_data(dac_data),
        .dma_req(dma_req), .underrun(underrun), .underrun_irq(underrun_irq),
        .sw_trig_pending(sw_trig_pending)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_xfer(input logic [11:0] v, input int at);
        if (v != exp_dac) begin
            q_val.push_back(v);
            q_cyc.push_back(at);
            exp_dac = v;
        end
    endtask

    // Register write; returns at the negedge after the sampling edge.
    task automatic wr(input logic [1:0] a, input logic [11:0] d, input logic direct);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 2'd1) begin
            exp_hold = d;
            if (direct) expect_xfer(d, cyc + 2);
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // One-cycle pulse on a hardware line; returns at negedge after acceptance.
    task automatic pulse(input int line, input logic accept);
        @(negedge clk);
        hw_trig_in[line] = 1'b1;
        if (accept) expect_xfer(exp_hold, cyc + 4);
        @(negedge clk);
        hw_trig_in[line] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: every output change must match the head of the queue.
    always @(negedge clk) begin
        if (mon_on && dac_data != last_dac) begin
            if (q_val.size() == 0) begin
                check("R3/R5/R6 unexpected transfer", int'(dac_data), int'(last_dac));
            end else begin
                check("R2/R4/R7 transfer value", int'(dac_data), int'(q_val.pop_front()));
                check("R2/R4/R7 transfer cycle", cyc, q_cyc.pop_front());
            end
        end
        last_dac = dac_data;
    end

    // Watchdog.
    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 dac_data", int'(dac_data), 0);
        check("R1 flags", int'({dma_req, underrun, underrun_irq, sw_trig_pending}), 0);
        @(negedge clk); rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R2: untriggered, back-to-back writes
        wr(2'd0, 12'h000, 1'b0);
        wr(2'd1, 12'h123, 1'b1);
        wr(2'd1, 12'h456, 1'b1);
        idle(3);

        // R3, R5, R4: trigger on, select timer line 2
        wr(2'd0, 12'h005, 1'b0);
        wr(2'd1, 12'h0AB, 1'b0);        // R3: no transfer expected
        idle(5);
        pulse(0, 1'b0);                  // R5: unselected line
        idle(5);
        pulse(2, 1'b1);                  // R4: selected line
        check("R8 no request without DMA", int'(dma_req), 0);
        idle(5);

        // R4: external line (code 6)
        wr(2'd0, 12'h00D, 1'b0);
        wr(2'd1, 12'h777, 1'b0);
        pulse(6, 1'b1);
        idle(5);

        // R6: second pulse inside busy window, then new holding value
        wr(2'd1, 12'h3C3, 1'b0);
        pulse(6, 1'b1);                  // accepted at E0
        @(negedge clk); hw_trig_in[6] = 1'b1;   // sampled at E0+2: ignored
        @(negedge clk); hw_trig_in[6] = 1'b0;
        wr(2'd1, 12'h5A5, 1'b0);         // would show if retriggered
        idle(6);

        // R5: trigger disabled, code 6 selected; R7 ignored software write
        wr(2'd0, 12'h00C, 1'b0);
        pulse(6, 1'b0);
        wr(2'd3, 12'h001, 1'b0);
        check("R7 ignored sw write", int'(sw_trig_pending), 0);
        idle(5);

        // R7: software trigger
        wr(2'd0, 12'h00F, 1'b0);
        wr(2'd1, 12'h9C4, 1'b0);
        idle(3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 12'h001;
        expect_xfer(exp_hold, cyc + 2);
        @(negedge clk); reg_wr = 1'b0;
        check("R7 pending set", int'(sw_trig_pending), 1);
        @(negedge clk);
        check("R7 pending during transfer", int'(sw_trig_pending), 1);
        @(negedge clk);
        check("R7 pending cleared", int'(sw_trig_pending), 0);
        idle(3);

        // R8, R9, R10: DMA mode, timer line 0
        wr(2'd0, 12'h011, 1'b0);
        wr(2'd1, 12'h111, 1'b0);
        pulse(0, 1'b1);
        check("R8 request high", int'(dma_req), 1);
        @(negedge clk);
        check("R8 request one cycle", int'(dma_req), 0);
        idle(4);
        wr(2'd1, 12'h222, 1'b0);         // services the request
        pulse(0, 1'b1);
        check("R9 serviced: no underrun", int'(underrun), 0);
        idle(5);
        pulse(0, 1'b1);                  // not serviced
        check("R9 underrun set", int'(underrun), 1);
        check("R10 irq masked", int'(underrun_irq), 0);
        idle(5);
        check("R9 underrun sticky", int'(underrun), 1);
        wr(2'd0, 12'h031, 1'b0);
        check("R10 irq enabled", int'(underrun_irq), 1);
        wr(2'd2, 12'h001, 1'b0);
        check("R10 flag cleared", int'(underrun), 0);
        check("R10 irq cleared", int'(underrun_irq), 0);
        idle(6);

        check("R4 queue drained", q_val.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule